// File: doc/BRIEF.md
# Key-Binned Pair Matcher

The block joins records from two groups on equal keys in linear time. During the fill phase each group-1 record (key plus payload) is written to the next free slot of a payload memory. The slot is then linked to the front of a per-key chain. A key-indexed head table names the newest slot of each chain, and a link memory gives each slot its predecessor in the same bin.

During the probe phase each group-2 record reads its bin's head. The block then walks the chain one slot per cycle and emits one pair per cycle: the probe's key and payload together with one stored payload. Input is held off while a walk runs. A fill of n records costs n cycles. A probe costs one cycle plus one cycle per match.

Every head entry carries the generation number in which it was written. Pulsing `evt_next` moves to a new generation, which empties every bin at once with no clearing sweep. The same pulse also rewinds the free-slot counter and clears the overflow flag.

Top module: `pair_bin_matcher`

## Requirements
- R1: After reset `out_valid` and `overflow` are 0, `in_ready` is 1, and every bin is empty, so a probe of any key yields no pair.
- R2: A record accepted with `in_grp`=0 (store) is kept under its key and produces no output in the following cycle.
- R3: A record accepted with `in_grp`=1 (probe) whose bin holds m records raises `out_valid` for exactly m consecutive cycles. These start in the cycle after acceptance, with one stored payload per cycle, newest stored first.
- R4: A probe of an empty bin produces no `out_valid` cycle, and `in_ready` is 1 again in the next cycle.
- R5: `in_ready` is 0 in every cycle in which `out_valid` is 1. It is 1 whenever neither a walk nor `evt_next` is active.
- R6: While `evt_next` is 1, `in_ready` is 0. From the next cycle every bin is empty, the free-slot count is 0 and `overflow` is 0.
- R7: At most DEPTH (256) stores are kept per generation. A further store is dropped and sets `overflow`, which stays 1 until `evt_next` or reset. Records already stored are unaffected.
- R8: During a walk `out_key` and `out_probe` equal the key and payload of the probe being served, and they stay stable for all of its pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_next | input | 1 | Start a new generation: empty all bins, rewind storage |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Block accepts a record this cycle |
| in_grp | input | 1 | 0 = store (group 1), 1 = probe (group 2) |
| in_key | input | 8 | Record key |
| in_data | input | 16 | Record payload |
| out_valid | output | 1 | A pair is presented this cycle |
| out_key | output | 8 | Key of the probe being served |
| out_probe | output | 16 | Payload of the probe being served |
| out_stored | output | 16 | Payload of the matched stored record |
| overflow | output | 1 | A store was dropped for lack of space |

## Verification
On every cycle the assertions check the stall rule against the walk, that a store never starts output, that a walk begins only after an accepted probe, the stability of the probe fields across a walk, and the sticky overflow with its clearing by a generation step. Which payloads come out, how many, and in what order depends on the whole stream of stores before a probe. Only the bench's scenarios can show this: random fills over a small key set, empty-bin probes, a generation step over filled bins, and filling past capacity.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

    typedef enum logic {
        GRP_STORE = 1'b0,
        GRP_PROBE = 1'b1
    } grp_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } walk_e;

    function automatic logic below_limit(input int unsigned count, input int unsigned limit);
        return count < limit;
    endfunction

endpackage

// File: rtl/pbm_head_table.sv
module pbm_head_table #(
    parameter int KEY_W = 8,
    parameter int AW    = 8,
    parameter int GEN_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [KEY_W-1:0] rd_key,
    output logic             rd_hit,
    output logic [AW-1:0]    rd_addr,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [AW-1:0]    wr_addr,
    input  logic [GEN_W-1:0] cur_gen
);
    localparam int BINS = 1 << KEY_W;

    typedef struct packed {
        logic             used;
        logic [GEN_W-1:0] tag;
        logic [AW-1:0]    addr;
    } head_t;

    head_t tbl [BINS];
    head_t rd_ent;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BINS; i++) begin
                tbl[i] <= '0;
            end
        end else if (wr_en) begin
            tbl[wr_key] <= '{used: 1'b1, tag: cur_gen, addr: wr_addr};
        end
    end

    assign rd_ent  = tbl[rd_key];
    assign rd_hit  = rd_ent.used && (rd_ent.tag == cur_gen);
    assign rd_addr = rd_ent.addr;

endmodule

// File: rtl/pbm_link_store.sv
module pbm_link_store #(
    parameter int DATA_W = 16,
    parameter int AW     = 8,
    parameter int DEPTH  = 256
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_nxt_vld,
    input  logic [AW-1:0]     wr_nxt_addr,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_nxt_vld,
    output logic [AW-1:0]     rd_nxt_addr
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
    } link_t;

    logic [DATA_W-1:0] data_mem [DEPTH];
    link_t             link_mem [DEPTH];
    link_t             rd_link;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_addr] <= wr_data;
            link_mem[wr_addr] <= '{vld: wr_nxt_vld, addr: wr_nxt_addr};
        end
    end

    assign rd_data     = data_mem[rd_addr];
    assign rd_link     = link_mem[rd_addr];
    assign rd_nxt_vld  = rd_link.vld;
    assign rd_nxt_addr = rd_link.addr;

endmodule

// File: rtl/pbm_ctrl.sv
module pbm_ctrl
    import pbm_pkg::*;
#(
    parameter int KEY_W  = 8,
    parameter int DATA_W = 16,
    parameter int AW     = 8,
    parameter int DEPTH  = 256,
    parameter int GEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_next,
    input  logic              in_valid,
    input  logic              in_grp,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              head_hit,
    input  logic [AW-1:0]     head_addr,
    input  logic              nxt_vld,
    input  logic [AW-1:0]     nxt_addr,
    output logic              store_we,
    output logic [AW-1:0]     store_addr,
    output logic [AW-1:0]     walk_addr,
    output logic              walking,
    output logic [KEY_W-1:0]  probe_key,
    output logic [DATA_W-1:0] probe_data,
    output logic              overflow,
    output logic [GEN_W-1:0]  cur_gen
);
    localparam int CNT_W = AW + 1;

    walk_e             state;
    grp_e              grp;
    logic [CNT_W-1:0]  free_cnt;
    logic [AW-1:0]     cur;
    logic              accept;
    logic              has_room;

    assign grp      = grp_e'(in_grp);
    assign in_ready = (state == ST_IDLE) && !evt_next;
    assign accept   = in_valid && in_ready;
    assign has_room = below_limit(int'(free_cnt), DEPTH);
    assign store_we = accept && (grp == GRP_STORE) && has_room;

    assign store_addr = free_cnt[AW-1:0];
    assign walk_addr  = cur;
    assign walking    = (state == ST_WALK);

    // Generation, free slots and overflow
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_gen  <= '0;
            free_cnt <= '0;
            overflow <= 1'b0;
        end else if (evt_next) begin
            cur_gen  <= cur_gen + GEN_W'(1);
            free_cnt <= '0;
            overflow <= 1'b0;
        end else if (accept && (grp == GRP_STORE)) begin
            if (has_room) begin
                free_cnt <= free_cnt + CNT_W'(1);
            end else begin
                overflow <= 1'b1;
            end
        end
    end

    // Chain walker
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            cur        <= '0;
            probe_key  <= '0;
            probe_data <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept && (grp == GRP_PROBE) && head_hit) begin
                        state      <= ST_WALK;
                        cur        <= head_addr;
                        probe_key  <= in_key;
                        probe_data <= in_data;
                    end
                end
                ST_WALK: begin
                    if (nxt_vld) begin
                        cur <= nxt_addr;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pair_bin_matcher.sv
module pair_bin_matcher #(
    parameter int KEY_W  = 8,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 256,
    parameter int GEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_next,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_grp,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [KEY_W-1:0]  out_key,
    output logic [DATA_W-1:0] out_probe,
    output logic [DATA_W-1:0] out_stored,
    output logic              overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              head_hit;
    logic [AW-1:0]     head_addr;
    logic              nxt_vld;
    logic [AW-1:0]     nxt_addr;
    logic              store_we;
    logic [AW-1:0]     store_addr;
    logic [AW-1:0]     walk_addr;
    logic [GEN_W-1:0]  cur_gen;

    pbm_head_table #(.KEY_W(KEY_W), .AW(AW), .GEN_W(GEN_W)) u_head (
        .clk     (clk),
        .rst     (rst),
        .rd_key  (in_key),
        .rd_hit  (head_hit),
        .rd_addr (head_addr),
        .wr_en   (store_we),
        .wr_key  (in_key),
        .wr_addr (store_addr),
        .cur_gen (cur_gen)
    );

    pbm_link_store #(.DATA_W(DATA_W), .AW(AW), .DEPTH(DEPTH)) u_store (
        .clk         (clk),
        .wr_en       (store_we),
        .wr_addr     (store_addr),
        .wr_data     (in_data),
        .wr_nxt_vld  (head_hit),
        .wr_nxt_addr (head_addr),
        .rd_addr     (walk_addr),
        .rd_data     (out_stored),
        .rd_nxt_vld  (nxt_vld),
        .rd_nxt_addr (nxt_addr)
    );

    pbm_ctrl #(
        .KEY_W(KEY_W), .DATA_W(DATA_W), .AW(AW), .DEPTH(DEPTH), .GEN_W(GEN_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .evt_next   (evt_next),
        .in_valid   (in_valid),
        .in_grp     (in_grp),
        .in_key     (in_key),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .head_hit   (head_hit),
        .head_addr  (head_addr),
        .nxt_vld    (nxt_vld),
        .nxt_addr   (nxt_addr),
        .store_we   (store_we),
        .store_addr (store_addr),
        .walk_addr  (walk_addr),
        .walking    (out_valid),
        .probe_key  (out_key),
        .probe_data (out_probe),
        .overflow   (overflow),
        .cur_gen    (cur_gen)
    );

endmodule

// File: rtl/pbm_checker.sv
module pbm_checker #(
    parameter int KEY_W  = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              evt_next,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_grp,
    input logic              out_valid,
    input logic [KEY_W-1:0]  out_key,
    input logic [DATA_W-1:0] out_probe,
    input logic              overflow
);
    AST_STALL_WHILE_WALK: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R5

    AST_READY_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !evt_next) |-> in_ready); // R5

    AST_STORE_SILENT: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !in_grp) |=> !out_valid); // R2

    AST_WALK_NEEDS_PROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready && in_grp)); // R3

    AST_PROBE_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> ($stable(out_key) && $stable(out_probe))); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (overflow && !evt_next) |=> overflow); // R7

    AST_EVT_CLEARS_OVF: assert property (@(posedge clk) disable iff (rst)
        evt_next |=> !overflow); // R6

    AST_EVT_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
        evt_next |-> !in_ready); // R6

endmodule

bind pair_bin_matcher pbm_checker #(.KEY_W(KEY_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_next  (evt_next),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_grp    (in_grp),
    .out_valid (out_valid),
    .out_key   (out_key),
    .out_probe (out_probe),
    .overflow  (overflow)
);

// File: tb/pair_bin_matcher_bench.sv
module pair_bin_matcher_bench;
    localparam int KEY_W  = 8;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 256;
    localparam int BINS   = 1 << KEY_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              evt_next = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic              in_grp = 1'b0;
    logic [KEY_W-1:0]  in_key = '0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic [KEY_W-1:0]  out_key;
    logic [DATA_W-1:0] out_probe;
    logic [DATA_W-1:0] out_stored;
    logic              overflow;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference model
    logic [DATA_W-1:0] mbin [BINS][$];
    int                m_cnt = 0;
    bit                m_ovf = 1'b0;

    always #4 clk = ~clk;

    pair_bin_matcher #(.KEY_W(KEY_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_pair_bin_matcher (
        .clk        (clk),
        .rst        (rst),
        .evt_next   (evt_next),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_grp     (in_grp),
        .in_key     (in_key),
        .in_data    (in_data),
        .out_valid  (out_valid),
        .out_key    (out_key),
        .out_probe  (out_probe),
        .out_stored (out_stored),
        .overflow   (overflow)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit model_fits();
        return m_cnt < DEPTH;
    endfunction

    task automatic model_store(input int key, input logic [DATA_W-1:0] d);
        if (model_fits()) begin
            mbin[key].push_front(d);
            m_cnt++;
        end else begin
            m_ovf = 1'b1;
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < BINS; k++) mbin[k].delete();
        m_cnt = 0;
        m_ovf = 1'b0;
    endtask

    task automatic do_store(input int key, input logic [DATA_W-1:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_grp = 1'b0; in_key = KEY_W'(key); in_data = d;
        #1 chk("R5 ready before store", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        model_store(key, d);
        #1 chk("R2 no output after store", 32'(out_valid), 32'd0);
        chk("R7 overflow after store", 32'(overflow), 32'(m_ovf));
    endtask

    task automatic do_probe(input int key, input logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] expq [$];
        expq = mbin[key];
        @(negedge clk);
        in_valid = 1'b1; in_grp = 1'b1; in_key = KEY_W'(key); in_data = d;
        #1 chk("R5 ready before probe", 32'(in_ready), 32'd1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        for (int i = 0; i < expq.size(); i++) begin
            chk("R3 pair valid", 32'(out_valid), 32'd1);
            chk("R3 stored payload order", 32'(out_stored), 32'(expq[i]));
            chk("R8 probe key", 32'(out_key), 32'(key));
            chk("R8 probe payload", 32'(out_probe), 32'(d));
            chk("R5 stalled during walk", 32'(in_ready), 32'd0);
            @(negedge clk);
            #1;
        end
        if (expq.size() == 0) begin
            chk("R4 empty bin silent", 32'(out_valid), 32'd0);
            chk("R4 ready after empty probe", 32'(in_ready), 32'd1);
        end else begin
            chk("R3 walk ends after last pair", 32'(out_valid), 32'd0);
            chk("R5 ready after walk", 32'(in_ready), 32'd1);
        end
    endtask

    task automatic do_evt();
        @(negedge clk);
        evt_next = 1'b1;
        #1 chk("R6 ready low on generation step", 32'(in_ready), 32'd0);
        @(posedge clk);
        @(negedge clk);
        evt_next = 1'b0;
        model_clear();
        #1 chk("R6 overflow cleared", 32'(overflow), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk("R1 out_valid at reset", 32'(out_valid), 32'd0);
        chk("R1 overflow at reset", 32'(overflow), 32'd0);
        chk("R1 in_ready at reset", 32'(in_ready), 32'd1);
        do_probe(0, 16'h1111);
        do_probe(255, 16'h2222);
        do_probe(77, 16'h3333);

        // Directed: three stores in one bin, newest first (R3)
        do_store(5, 16'hA001);
        do_store(5, 16'hA002);
        do_store(9, 16'hB001);
        do_store(5, 16'hA003);
        do_probe(5, 16'hC0DE);
        do_probe(9, 16'hC0DF);
        do_probe(6, 16'hDEAD);   // R4 empty neighbour
        do_probe(5, 16'hC0E0);   // chains survive probing

        // Random fill and probe over a small key set
        for (int n = 0; n < 60; n++) begin
            if ($urandom_range(2, 0) != 0)
                do_store(int'($urandom_range(15, 0)), DATA_W'($urandom()));
            else
                do_probe(int'($urandom_range(15, 0)), DATA_W'($urandom()));
        end
        for (int k = 0; k < 16; k++) do_probe(k, DATA_W'($urandom()));

        // R6: generation step empties filled bins
        do_evt();
        for (int k = 0; k < 16; k++) do_probe(k, 16'h0F0F);
        do_store(3, 16'h7777);
        do_probe(3, 16'h8888);   // single-entry chain

        // R7: fill to capacity, then one more
        do_evt();
        for (int n = 0; n < DEPTH; n++) do_store(int'($urandom_range(7, 0)), DATA_W'(n));
        chk("R7 no overflow at exactly full", 32'(overflow), 32'd0);
        do_store(3, 16'hFFFF);
        chk("R7 overflow after extra store", 32'(overflow), 32'd1);
        do_probe(3, 16'h4242);   // dropped record must not appear
        do_probe(0, 16'h4343);
        chk("R7 overflow sticky", 32'(overflow), 32'd1);
        do_evt();
        do_probe(3, 16'h4444);
        do_store(1, 16'h1234);
        do_probe(1, 16'h5678);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule